// File: doc/BRIEF.md
# Beam-Synchronized Display List Coprocessor

This block walks a list of two-word instructions stored in memory and fetches each word itself over a request/grant port, without the processor's help. It supports two instruction kinds. The first stalls the list until the raster beam has reached a programmed vertical and horizontal position. The second writes an immediate 16-bit value into any chip register through a generic address/data write port. Colour, scroll, sprite, audio, interrupt and blitter-start registers all sit behind that port, so a list can change them at exact points on the screen, line by line, partway down a frame.

A frame-restart strobe, normally driven at vertical blank, reloads the list pointer from the `list_base` input and starts fetching again. The timing generator that supplies the beam counters, the memory arbiter that answers requests, and the registers that receive the writes are all outside the block.

Top module: `beam_list_engine`

## Requirements
- R1: While reset is active, and after reset until the first frame-restart strobe, `mem_req` and `wr_en` stay low.
- R2: A frame-restart strobe sampled at a clock edge makes `mem_req` high with `mem_addr` equal to the sampled `list_base` in the following cycle.
- R3: While `mem_req` is high and `mem_gnt` is low, the request and its address are held unchanged. A word is taken in the cycle in which `mem_gnt` is high.
- R4: The two words of an instruction are fetched at consecutive word addresses, and the next instruction starts two addresses after the current one.
- R5: A first word with bit 0 equal to 0 is a register write. The cycle after the second word is granted, `wr_en` is high for exactly one cycle, `wr_addr` equals the low `RAW` bits of the first word, and `wr_data` equals the whole second word, whatever its value (odd values included).
- R6: A first word with bit 0 equal to 1 is a beam wait with vertical target V = bits 15:8 and horizontal target H = 2 × bits 7:1. No fetch is requested while the beam is short of the target. The beam counts as having reached the target when `beam_v` > V, or when `beam_v` = V and `beam_h` ≥ H. The fetch of the next instruction starts in the cycle after the target is reached.
- R7: The vertical position takes precedence. A beam line above the target satisfies the wait for any horizontal value, and a line below it does not satisfy the wait for any horizontal value.
- R8: A wait whose first word is 16'hFFFF (line 255, position 254) ends the list. No further fetch occurs, whatever the beam position, until the next frame-restart strobe.
- R9: A frame-restart strobe has priority over any instruction in progress. If it coincides with the grant of a register write's second word, no write is issued, and fetching restarts at `list_base`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| frame_restart | input | 1 | One-cycle strobe that reloads the list pointer |
| list_base | input | AW | Word address of the first instruction |
| beam_v | input | 8 | Current beam line |
| beam_h | input | 8 | Current beam horizontal position |
| mem_req | output | 1 | Word fetch request |
| mem_addr | output | AW | Word address of the fetch |
| mem_gnt | input | 1 | Grant; `mem_rdata` is valid in the same cycle |
| mem_rdata | input | 16 | Fetched word |
| wr_en | output | 1 | Register write strobe |
| wr_addr | output | RAW | Register address of the write |
| wr_data | output | 16 | Data for the write |

## Verification
The wait comparison is tried with beam positions that sit exactly on the target, one horizontal step short, on an odd position that shares the target's pair, on the line just above or below with extreme horizontal values, and at the end-of-list code. These cases separate an inclusive compare from a strict one, show whether the horizontal low bit is ignored, and show whether the vertical field dominates. Register-write lists use odd and high-bit data so that a corrupted data path shows up. Fetches are stalled by withholding the grant, which exposes any drift of the request or its address. A restart strobe is placed on the grant of a write's second word, which separates a design that drops the write from one that lets it through.

// File: rtl/ble_pkg.sv
package ble_pkg;
  localparam int WORD_W  = 16;
  localparam int BEAM_W  = 8;
  localparam int KIND_B  = 0;
  localparam int VT_HI   = 15;
  localparam int VT_LO   = 8;
  localparam int HT_HI   = 7;
  localparam int HT_LO   = 1;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_FETCH_A = 3'd1,
    ST_FETCH_B = 3'd2,
    ST_WAIT    = 3'd3,
    ST_HALT    = 3'd4
  } ble_state_e;
endpackage

// File: rtl/ble_rst_sync.sv
module ble_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= 2'b00;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/ble_fetch_ptr.sv
module ble_fetch_ptr #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          step,
  input  logic [AW-1:0] base,
  output logic [AW-1:0] ptr
);
  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_d  = ptr_q;
    ptr_en = load | step;
    if (load)      ptr_d = base;
    else if (step) ptr_d = ptr_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      ptr_q <= '0;
    else if (ptr_en) ptr_q <= ptr_d;
  end

  assign ptr = ptr_q;

  // R4: each accepted word moves the pointer by exactly one
  a_r4_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (ptr_q == $past(ptr_q) + 1'b1));
endmodule

// File: rtl/ble_beam_cmp.sv
module ble_beam_cmp
  import ble_pkg::*;
(
  input  logic [BEAM_W-1:0]   beam_v,
  input  logic [BEAM_W-1:0]   beam_h,
  input  logic [WORD_W-1:1]   wait_word,
  output logic                reached,
  output logic                is_end
);
  localparam int HT_W = HT_HI - HT_LO + 1;

  logic [BEAM_W-1:0] tgt_v;
  logic [BEAM_W-1:0] tgt_h;
  logic              v_above;
  logic              v_equal;
  logic              h_at;

  always_comb begin
    tgt_v   = wait_word[VT_HI:VT_LO];
    tgt_h   = {wait_word[HT_HI:HT_LO], 1'b0};
    is_end  = &wait_word;
    v_above = beam_v > tgt_v;
    v_equal = beam_v == tgt_v;
    h_at    = beam_h >= tgt_h;
    reached = !is_end && (v_above || (v_equal && h_at));
  end

  initial begin
    if (HT_W + 1 != BEAM_W) $error("horizontal field does not match beam width");
  end
endmodule

// File: rtl/ble_reg_writer.sv
module ble_reg_writer #(
  parameter int RAW = 9,
  parameter int DW  = 16
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fire,
  input  logic [RAW-1:0] addr_in,
  input  logic [DW-1:0]  data_in,
  output logic           wr_en,
  output logic [RAW-1:0] wr_addr,
  output logic [DW-1:0]  wr_data
);
  logic           en_q;
  logic [RAW-1:0] addr_q;
  logic [DW-1:0]  data_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b0;
    else        en_q <= fire;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (fire) begin
      addr_q <= addr_in;
      data_q <= data_in;
    end
  end

  assign wr_en   = en_q;
  assign wr_addr = addr_q;
  assign wr_data = data_q;

  // R5: a write strobe never lasts more than one cycle
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> !wr_en);

  // R5: address and data presented with the strobe are the ones captured
  a_r5_payload: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (wr_en && wr_data == $past(data_in) && wr_addr == $past(addr_in)));
endmodule

// File: rtl/beam_list_engine.sv
module beam_list_engine
  import ble_pkg::*;
#(
  parameter int AW  = 16,
  parameter int RAW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_restart,
  input  logic [AW-1:0]     list_base,
  input  logic [7:0]        beam_v,
  input  logic [7:0]        beam_h,
  output logic              mem_req,
  output logic [AW-1:0]     mem_addr,
  input  logic              mem_gnt,
  input  logic [15:0]       mem_rdata,
  output logic              wr_en,
  output logic [RAW-1:0]    wr_addr,
  output logic [15:0]       wr_data
);
  localparam int RAW_OK = (RAW <= WORD_W) ? 1 : 0;

  logic              rst_s_n;
  ble_state_e        state_q;
  ble_state_e        state_d;
  logic [WORD_W-1:0] w1_q;
  logic              w1_ld;
  logic              ptr_step;
  logic              wr_fire;
  logic              reached;
  logic              is_end;
  logic              is_move;

  ble_rst_sync u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_s_n)
  );

  ble_fetch_ptr #(.AW(AW)) u_ptr (
    .clk   (clk),
    .rst_n (rst_s_n),
    .load  (frame_restart),
    .step  (ptr_step),
    .base  (list_base),
    .ptr   (mem_addr)
  );

  ble_beam_cmp u_cmp (
    .beam_v    (beam_v),
    .beam_h    (beam_h),
    .wait_word (w1_q[WORD_W-1:1]),
    .reached   (reached),
    .is_end    (is_end)
  );

  ble_reg_writer #(.RAW(RAW), .DW(WORD_W)) u_wr (
    .clk     (clk),
    .rst_n   (rst_s_n),
    .fire    (wr_fire),
    .addr_in (w1_q[RAW-1:0]),
    .data_in (mem_rdata),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data)
  );

  assign is_move = (w1_q[KIND_B] == 1'b0);

  // next-state process
  always_comb begin
    state_d  = state_q;
    w1_ld    = 1'b0;
    ptr_step = 1'b0;
    wr_fire  = 1'b0;
    if (frame_restart) begin
      state_d = ST_FETCH_A;
    end else begin
      case (state_q)
        ST_FETCH_A: begin
          if (mem_gnt) begin
            w1_ld    = 1'b1;
            ptr_step = 1'b1;
            state_d  = ST_FETCH_B;
          end
        end
        ST_FETCH_B: begin
          if (mem_gnt) begin
            ptr_step = 1'b1;
            if (is_move) begin
              wr_fire = 1'b1;
              state_d = ST_FETCH_A;
            end else if (is_end) begin
              state_d = ST_HALT;
            end else begin
              state_d = ST_WAIT;
            end
          end
        end
        ST_WAIT: begin
          if (reached) state_d = ST_FETCH_A;
        end
        default: state_d = state_q;
      endcase
    end
  end

  // register processes
  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n) state_q <= ST_IDLE;
    else          state_q <= state_d;
  end

  always_ff @(posedge clk or negedge rst_s_n) begin
    if (!rst_s_n)   w1_q <= '0;
    else if (w1_ld) w1_q <= mem_rdata;
  end

  assign mem_req = (state_q == ST_FETCH_A) || (state_q == ST_FETCH_B);

  initial begin
    if (RAW_OK == 0) $error("register address wider than an instruction word");
  end

  // R1: nothing leaves the block before the first restart
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_IDLE) |-> (!mem_req && !wr_en));

  // R2: a restart points the next request at the base address
  a_r2_restart_fetch: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_restart |=> (mem_req && mem_addr == $past(list_base)));

  // R3: an ungranted request keeps its address
  a_r3_hold_request: assert property (@(posedge clk) disable iff (!rst_s_n)
    (mem_req && !mem_gnt && !frame_restart) |=> (mem_req && $stable(mem_addr)));

  // R6: no fetch while the beam is short of the target
  a_r6_wait_no_req: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_WAIT && !reached && !frame_restart) |=> !mem_req);

  // R8: the end-of-list wait stays silent until a restart
  a_r8_halt_sticky: assert property (@(posedge clk) disable iff (!rst_s_n)
    (state_q == ST_HALT && !frame_restart) |=> (!mem_req && !wr_en));

  // R9: a restart cycle never produces a write
  a_r9_restart_no_write: assert property (@(posedge clk) disable iff (!rst_s_n)
    frame_restart |=> !wr_en);
endmodule

// File: tb/sim_beam_list_engine.sv
module sim_beam_list_engine;
  localparam int CLK_PERIOD = 10;
  localparam int AW  = 16;
  localparam int RAW = 9;
  localparam int NV  = 10;

  // {expect_write, wait word, beam_v, beam_h}
  localparam logic [32:0] VEC [NV] = '{
    {1'b1, 16'h4041, 8'h40, 8'h40},
    {1'b0, 16'h4041, 8'h40, 8'h3F},
    {1'b1, 16'h4041, 8'h40, 8'h41},
    {1'b0, 16'h4041, 8'h3F, 8'hFF},
    {1'b1, 16'h4041, 8'h41, 8'h00},
    {1'b1, 16'h0001, 8'h00, 8'h00},
    {1'b0, 16'hFFFF, 8'hFF, 8'hFF},
    {1'b1, 16'hFFFD, 8'hFF, 8'hFD},
    {1'b1, 16'h80FF, 8'h80, 8'hFE},
    {1'b0, 16'h80FF, 8'h80, 8'hFD}
  };

  logic           clk;
  logic           rst_n;
  logic           frame_restart;
  logic [AW-1:0]  list_base;
  logic [7:0]     beam_v;
  logic [7:0]     beam_h;
  logic           mem_req;
  logic [AW-1:0]  mem_addr;
  logic           mem_gnt;
  logic [15:0]    mem_rdata;
  logic           wr_en;
  logic [RAW-1:0] wr_addr;
  logic [15:0]    wr_data;

  logic           gnt_en;
  logic [15:0]    mem [64];

  int             errors;
  int             checks;
  int             cyc;
  int             g_n;
  logic [AW-1:0]  g_addr [64];
  int             g_cyc  [64];
  int             w_n;
  logic [RAW-1:0] w_addr [64];
  logic [15:0]    w_data [64];
  int             w_cyc  [64];
  int             mark_g;
  int             mark_w;

  beam_list_engine #(.AW(AW), .RAW(RAW)) u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .frame_restart (frame_restart),
    .list_base     (list_base),
    .beam_v        (beam_v),
    .beam_h        (beam_h),
    .mem_req       (mem_req),
    .mem_addr      (mem_addr),
    .mem_gnt       (mem_gnt),
    .mem_rdata     (mem_rdata),
    .wr_en         (wr_en),
    .wr_addr       (wr_addr),
    .wr_data       (wr_data)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always_comb begin
    mem_rdata = mem[mem_addr[5:0]];
    mem_gnt   = mem_req & gnt_en;
  end

  // monitor: samples in the middle of the cycle
  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (mem_req && mem_gnt && g_n < 64) begin
      g_addr[g_n] <= mem_addr;
      g_cyc[g_n]  <= cyc;
      g_n         <= g_n + 1;
    end
    if (wr_en && w_n < 64) begin
      w_addr[w_n] <= wr_addr;
      w_data[w_n] <= wr_data;
      w_cyc[w_n]  <= cyc;
      w_n         <= w_n + 1;
    end
  end

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic restart(input logic [AW-1:0] base);
    list_base     = base;
    frame_restart = 1'b1;
    step();
    frame_restart = 1'b0;
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errors, checks);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    errors = 0; checks = 0; cyc = 0; g_n = 0; w_n = 0;
    rst_n = 1'b0; frame_restart = 1'b0; list_base = '0;
    beam_v = '0; beam_h = '0; gnt_en = 1'b1;
    for (int i = 0; i < 64; i++) mem[i] = 16'hFFFF;

    // R1: reset and idle before any restart
    repeat (3) step();
    chk("R1 req in reset", {31'd0, mem_req}, 32'd0);
    chk("R1 wr in reset", {31'd0, wr_en}, 32'd0);
    rst_n = 1'b1;
    repeat (6) step();
    chk("R1 req idle", {31'd0, mem_req}, 32'd0);
    chk("R1 no grants", g_n, 0);

    // table: wait comparison (R6, R7, R8)
    for (int i = 0; i < NV; i++) begin
      mem[4] = VEC[i][31:16];
      mem[5] = 16'h0000;
      mem[6] = 16'h0042;
      mem[7] = 16'hA000 + 16'(i);
      mem[8] = 16'hFFFF;
      mem[9] = 16'h0000;
      beam_v = VEC[i][15:8];
      beam_h = VEC[i][7:0];
      mark_w = w_n;
      restart(16'h0004);
      repeat (12) step();
      chk($sformatf("R6 R7 R8 vector %0d write count", i), w_n - mark_w, {31'd0, VEC[i][32]});
      if (VEC[i][32] && w_n > mark_w)
        chk($sformatf("R6 vector %0d data", i), {16'd0, w_data[w_n-1]}, 32'hA000 + i);
    end

    // R2, R3: restart address and held request
    mem[16] = 16'h00A2; mem[17] = 16'h1235;
    mem[18] = 16'h00C4; mem[19] = 16'hBEEF;
    mem[20] = 16'hFFFF; mem[21] = 16'h0000;
    gnt_en = 1'b0;
    beam_v = 8'h00; beam_h = 8'h00;
    step();
    mark_g = g_n;
    mark_w = w_n;
    restart(16'h0010);
    chk("R2 req after restart", {31'd0, mem_req}, 32'd1);
    chk("R2 addr after restart", {16'd0, mem_addr}, 32'h10);
    repeat (4) step();
    chk("R3 req held", {31'd0, mem_req}, 32'd1);
    chk("R3 addr held", {16'd0, mem_addr}, 32'h10);
    chk("R3 no grant taken", g_n - mark_g, 0);
    gnt_en = 1'b1;
    repeat (12) step();

    // R4: consecutive word addresses
    chk("R4 grant count", g_n - mark_g, 6);
    for (int k = 0; k < 6; k++)
      chk("R4 fetch order", {16'd0, g_addr[mark_g + k]}, 32'h10 + k);

    // R5: register writes
    chk("R5 write count", w_n - mark_w, 2);
    chk("R5 first addr", {23'd0, w_addr[mark_w]}, 32'h0A2);
    chk("R5 first data odd", {16'd0, w_data[mark_w]}, 32'h1235);
    chk("R5 second addr", {23'd0, w_addr[mark_w+1]}, 32'h0C4);
    chk("R5 second data", {16'd0, w_data[mark_w+1]}, 32'hBEEF);
    chk("R5 write timing", w_cyc[mark_w], g_cyc[mark_g+1] + 1);

    // R8: end of list holds at any beam position
    beam_v = 8'hFF; beam_h = 8'hFF;
    repeat (10) step();
    chk("R8 no fetch after end", g_n - mark_g, 6);
    chk("R8 req low after end", {31'd0, mem_req}, 32'd0);

    // R6: resume the cycle after the target is reached
    mem[48] = 16'h4041; mem[49] = 16'h0000;
    mem[50] = 16'h0050; mem[51] = 16'h7777;
    mem[52] = 16'hFFFF; mem[53] = 16'h0000;
    beam_v = 8'h40; beam_h = 8'h3E;
    mark_g = g_n;
    restart(16'h0030);
    repeat (8) step();
    chk("R6 only wait fetched", g_n - mark_g, 2);
    chk("R6 no req while short", {31'd0, mem_req}, 32'd0);
    beam_h = 8'h40;
    step();
    chk("R6 req after reach", {31'd0, mem_req}, 32'd1);
    chk("R6 addr after reach", {16'd0, mem_addr}, 32'h32);
    repeat (8) step();

    // R9: restart on the grant of a write's second word
    mem[32] = 16'h0060; mem[33] = 16'h5555;
    mem[34] = 16'hFFFF; mem[35] = 16'h0000;
    mem[40] = 16'hFFFF; mem[41] = 16'h0000;
    mark_w = w_n;
    mark_g = g_n;
    restart(16'h0020);
    step();
    restart(16'h0028);
    repeat (10) step();
    chk("R9 write dropped", w_n - mark_w, 0);
    chk("R9 refetch at new base", {16'd0, g_addr[mark_g + 2]}, 32'h28);

    summary();
    $finish;
  end
endmodule